// File: doc/BRIEF.md
# MSI Capability and Message Generator

This block holds the configuration registers of a single-vector message-signalled interrupt capability and turns a device's level interrupt request into interrupt traffic. Software programs a 64-bit message address and a 16-bit message payload through a dword-wide configuration port with byte enables, and sets one enable bit to choose the delivery path. The capability occupies four consecutive dwords starting at a parameterised base offset. The default base is 0x50, which places the address low, address high and payload dwords at 0x54, 0x58 and 0x5C.

With the enable bit set, each new assertion of the interrupt request produces exactly one posted dword memory write on a valid/ready port. The write carries the programmed address and the payload, with the payload's upper half forced to zero. The address and payload are captured when the message is launched, so later register writes do not change a message that is still waiting. With the enable bit clear, no writes are issued and a legacy INTx level follows the request instead.

Top module: `msi_msg_gen`

## Requirements
- R1: After a synchronous reset the enable bit, address and payload registers are 0. The control dword at the capability base reads 0x0080_0005, and msg_valid and intx_out are 0.
- R2: In the capability base dword, bits 7:0 are the read-only capability ID (parameter, default 0x05) and bits 15:8 are the read-only next pointer (parameter, default 0x00). Bit 16 is the read/write enable. Bits 22:17 read 0, bit 23 reads 1 (64-bit capable) and bits 31:24 read 0. Writes to the read-only bits have no effect.
- R3: Address low (base+4) stores bits 31:2 of what is written. Its bits 1:0 always read 0, and an emitted address always has bits 1:0 equal to 0.
- R4: Address high (base+8) is a full 32-bit read/write register and forms bits 63:32 of the emitted address.
- R5: The payload register (base+0xC) keeps the written bits 15:0, and bits 31:16 read 0. Every emitted msg_data has bits 31:16 equal to 0.
- R6: A register write changes only the bytes whose cfg_be bit (bit n selects cfg_wdata[8n+7:8n]) is 1. The enable bit is written only when cfg_be[2] is 1.
- R7: While enabled, each rising edge of irq_req sampled at a clock edge raises msg_valid in the following cycle. The message carries {address high, address low} and {16'h0, payload}. Exactly one message is produced per rising edge.
- R8: While disabled, no message is produced. Setting the enable bit while irq_req is already high produces no message.
- R9: While msg_valid is 1 and msg_ready is 0, the message is held with a stable address and payload. Further rising edges during the stall are dropped, and the message leaves at the first cycle in which msg_ready is 1.
- R10: intx_out equals irq_req while the enable bit is 0, and it is 0 while the enable bit is 1.
- R11: A synchronous reset discards a pending message (msg_valid is 0 in the cycle after reset) and clears the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte address (bits 1:0 ignored) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| irq_req | input | 1 | Level interrupt request from the device |
| intx_out | output | 1 | Legacy INTx level, active high |
| msg_valid | output | 1 | Posted write request valid |
| msg_ready | input | 1 | Posted write request accepted |
| msg_addr | output | 64 | Write address |
| msg_data | output | 32 | Write data dword |

## Verification
The bench stalls the output port and then fires a second request edge and rewrites the payload while the stall lasts. A design that re-captures live register values, or that queues a second message, shows up as a wrong or extra message in the scoreboard. It sets the enable bit while the request is already high: a design that treats the level rather than the edge as the trigger emits a spurious write. Partial-byte-enable writes and all-ones writes to the control dword expose lanes that ignore cfg_be and read-only bits that become writable. A reset issued during a stall catches a design that lets a held message escape afterwards.

// File: rtl/msi_pkg.sv
package msi_pkg;
   localparam int MSG_AW = 64;
   localparam int MSG_DW = 32;
   localparam int PAYLOAD_W = 16;
   localparam int CAP_DWORDS = 4;

   typedef enum logic [1:0] {
      DW_CTRL  = 2'd0,
      DW_ADRLO = 2'd1,
      DW_ADRHI = 2'd2,
      DW_DATA  = 2'd3
   } cap_dw_e;

   typedef struct packed {
      logic [MSG_AW-1:0] addr;
      logic [MSG_DW-1:0] data;
   } msi_msg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
   import msi_pkg::*;
#(
   parameter int CFG_AW = 8,
   parameter int CAP_BASE = 'h50,
   parameter logic [7:0] CAP_ID = 8'h05,
   parameter logic [7:0] NEXT_PTR = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              msi_en,
   output msi_msg_t          cur_msg
);
   localparam int DWI_W = CFG_AW - 2;
   localparam logic [DWI_W-1:0] BASE_DW = DWI_W'(CAP_BASE >> 2);
   localparam int PAY_BYTES = PAYLOAD_W / 8;

   if (CFG_AW < 5) begin : g_bad_aw
      $error("CFG_AW must be at least 5");
   end
   if ((CAP_BASE % 4) != 0) begin : g_bad_align
      $error("CAP_BASE must be dword aligned");
   end
   if (CAP_BASE + 4 * CAP_DWORDS > (1 << CFG_AW)) begin : g_bad_fit
      $error("capability does not fit in the configuration space");
   end

   logic [DWI_W-1:0] dw_off;
   logic             hit;
   cap_dw_e          sel;
   logic             en_q;
   logic [31:0]      adr_lo_q;
   logic [31:0]      adr_hi_q;
   logic [PAYLOAD_W-1:0] pay_q;
   logic             wr_lo, wr_hi, wr_pay, wr_ctrl;

   assign dw_off = cfg_addr[CFG_AW-1:2] - BASE_DW;
   assign hit    = (dw_off[DWI_W-1:2] == '0);
   assign sel    = cap_dw_e'(dw_off[1:0]);

   assign wr_ctrl = cfg_wr && hit && (sel == DW_CTRL);
   assign wr_lo   = cfg_wr && hit && (sel == DW_ADRLO);
   assign wr_hi   = cfg_wr && hit && (sel == DW_ADRHI);
   assign wr_pay  = cfg_wr && hit && (sel == DW_DATA);

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q <= 1'b0;
      end else if (wr_ctrl && cfg_be[2]) begin
         en_q <= cfg_wdata[16];
      end
   end

   for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            adr_hi_q[8*b +: 8] <= '0;
         end else if (wr_hi && cfg_be[b]) begin
            adr_hi_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
         end
      end
      if (b == 0) begin : g_lo_first
         always_ff @(posedge clk) begin
            if (rst) begin
               adr_lo_q[7:0] <= '0;
            end else if (wr_lo && cfg_be[0]) begin
               adr_lo_q[7:0] <= {cfg_wdata[7:2], 2'b00};
            end
         end
      end else begin : g_lo_rest
         always_ff @(posedge clk) begin
            if (rst) begin
               adr_lo_q[8*b +: 8] <= '0;
            end else if (wr_lo && cfg_be[b]) begin
               adr_lo_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
            end
         end
      end
      if (b < PAY_BYTES) begin : g_pay
         always_ff @(posedge clk) begin
            if (rst) begin
               pay_q[8*b +: 8] <= '0;
            end else if (wr_pay && cfg_be[b]) begin
               pay_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
            end
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (hit) begin
         case (sel)
            DW_CTRL:  cfg_rdata = {8'h00, 1'b1, 6'b000000, en_q, NEXT_PTR, CAP_ID};
            DW_ADRLO: cfg_rdata = adr_lo_q;
            DW_ADRHI: cfg_rdata = adr_hi_q;
            DW_DATA:  cfg_rdata = {{(32-PAYLOAD_W){1'b0}}, pay_q};
            default:  cfg_rdata = '0;
         endcase
      end
   end

   assign msi_en       = en_q;
   assign cur_msg.addr = {adr_hi_q, adr_lo_q};
   assign cur_msg.data = {{(MSG_DW-PAYLOAD_W){1'b0}}, pay_q};

   logic unused_bits;
   assign unused_bits = ^{cfg_addr[1:0], cfg_wdata[31:17], cfg_wdata[15:0], cfg_be[3]};
endmodule

// File: rtl/msi_msg_emit.sv
module msi_msg_emit
   import msi_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     irq_req,
   input  logic     msi_en,
   input  msi_msg_t cur_msg,
   input  logic     msg_ready,
   output logic     msg_valid,
   output msi_msg_t out_msg,
   output logic     intx_out
);
   logic     irq_q;
   logic     rise;
   logic     launch;
   logic     valid_q;
   msi_msg_t hold_q;

   assign rise   = irq_req && !irq_q;
   assign launch = rise && msi_en && (!valid_q || msg_ready);

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_q   <= 1'b0;
         valid_q <= 1'b0;
         hold_q  <= '0;
      end else begin
         irq_q <= irq_req;
         if (launch) begin
            valid_q <= 1'b1;
            hold_q  <= cur_msg;
         end else if (msg_ready) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign msg_valid = valid_q;
   assign out_msg   = hold_q;
   assign intx_out  = irq_req && !msi_en;
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
   import msi_pkg::*;
#(
   parameter int CFG_AW = 8,
   parameter int CAP_BASE = 'h50,
   parameter logic [7:0] CAP_ID = 8'h05,
   parameter logic [7:0] NEXT_PTR = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              irq_req,
   output logic              intx_out,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [63:0]       msg_addr,
   output logic [31:0]       msg_data
);
   logic     msi_en;
   msi_msg_t cur_msg;
   msi_msg_t out_msg;

   msi_cfg_regs #(
      .CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE), .CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR)
   ) u_regs (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msi_en(msi_en), .cur_msg(cur_msg)
   );

   msi_msg_emit u_emit (
      .clk(clk), .rst(rst), .irq_req(irq_req), .msi_en(msi_en), .cur_msg(cur_msg),
      .msg_ready(msg_ready), .msg_valid(msg_valid), .out_msg(out_msg), .intx_out(intx_out)
   );

   assign msg_addr = out_msg.addr;
   assign msg_data = out_msg.data;
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk (
   input logic        clk,
   input logic        rst,
   input logic        irq_req,
   input logic        msi_en,
   input logic        intx_out,
   input logic        msg_valid,
   input logic        msg_ready,
   input logic [63:0] msg_addr,
   input logic [31:0] msg_data
);
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R9

   AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> (msg_data[31:16] == 16'h0000)); // R5

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> (msg_addr[1:0] == 2'b00)); // R3

   AST_INTX_MASKED: assert property (@(posedge clk) disable iff (rst)
      msi_en |-> !intx_out); // R10

   AST_NO_MSG_DISABLED: assert property (@(posedge clk) disable iff (rst)
      (!msg_valid && !msi_en) |=> !msg_valid); // R8

   AST_RISE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
      (msi_en && $rose(irq_req) && !msg_valid) |=> msg_valid); // R7

   AST_RESET_DROP: assert property (@(posedge clk)
      rst |=> !msg_valid); // R11
endmodule

bind msi_msg_gen msi_msg_gen_chk u_chk (
   .clk(clk), .rst(rst), .irq_req(irq_req), .msi_en(msi_en), .intx_out(intx_out),
   .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msi_msg_gen_test.sv
module msi_msg_gen_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq_req = 1'b0;
   logic        intx_out;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int n_run = 0;
   int n_fail = 0;
   logic [95:0] exp_q[$];

   always #5 clk = ~clk;

   msi_msg_gen uut (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req), .intx_out(intx_out),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   task automatic chk(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(posedge clk); #1;
      cfg_addr = a;
      #1;
      chk(cfg_rdata === exp, req, {64'h0, cfg_rdata}, {64'h0, exp});
   endtask

   task automatic expect_msg(input logic [63:0] a, input logic [31:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic pulse_irq(input int hi_cycles);
      @(posedge clk); #1;
      irq_req = 1'b1;
      repeat (hi_cycles) @(posedge clk);
      #1;
      irq_req = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   // monitor: pop and compare each accepted message (R7)
   always @(negedge clk) begin
      if (!rst && msg_valid && msg_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7/R8 unexpected message", {msg_addr, msg_data}, 96'h0);
         end else begin
            logic [95:0] e;
            e = exp_q.pop_front();
            chk({msg_addr, msg_data} === e, "R7 message content", {msg_addr, msg_data}, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 96'h0, 96'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1 reset state
      cfg_check(8'h50, 32'h0080_0005, "R1 ctrl reset");
      cfg_check(8'h54, 32'h0, "R1 addr lo reset");
      cfg_check(8'h58, 32'h0, "R1 addr hi reset");
      cfg_check(8'h5C, 32'h0, "R1 data reset");
      chk(msg_valid === 1'b0 && intx_out === 1'b0, "R1 outputs", {94'h0, msg_valid, intx_out}, 96'h0);

      // R2 read-only control bits
      cfg_write(8'h50, 4'hF, 32'hFFFF_FFFF);
      cfg_check(8'h50, 32'h0081_0005, "R2 ctrl all ones");
      cfg_write(8'h50, 4'hF, 32'h0000_0000);
      cfg_check(8'h50, 32'h0080_0005, "R2 ctrl cleared");

      // R3 R4 R5 registers
      cfg_write(8'h54, 4'hF, 32'h1234_5677);
      cfg_check(8'h54, 32'h1234_5674, "R3 low bits forced 0");
      cfg_write(8'h58, 4'hF, 32'hDEAD_BEEF);
      cfg_check(8'h58, 32'hDEAD_BEEF, "R4 addr hi rw");
      cfg_write(8'h5C, 4'hF, 32'hABCD_5A5A);
      cfg_check(8'h5C, 32'h0000_5A5A, "R5 data upper zero");

      // R6 byte enables
      cfg_write(8'h54, 4'b0010, 32'hFFFF_FFFF);
      cfg_check(8'h54, 32'h1234_FF74, "R6 single lane");
      cfg_write(8'h50, 4'b0011, 32'hFFFF_FFFF);
      cfg_check(8'h50, 32'h0080_0005, "R6 enable needs be2");

      // R8 R10 disabled path
      msg_ready = 1'b1;
      @(posedge clk); #1 irq_req = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk(intx_out === 1'b1, "R10 intx follows irq", {95'h0, intx_out}, 96'h1);
      chk(msg_valid === 1'b0, "R8 no message disabled", {95'h0, msg_valid}, 96'h0);
      // enable while irq already high
      cfg_write(8'h50, 4'b0100, 32'h0001_0000);
      repeat (3) @(posedge clk);
      #2;
      chk(msg_valid === 1'b0, "R8 enable with irq high", {95'h0, msg_valid}, 96'h0);
      chk(intx_out === 1'b0, "R10 intx masked", {95'h0, intx_out}, 96'h0);
      @(posedge clk); #1 irq_req = 1'b0;
      repeat (2) @(posedge clk);

      // R7 messages
      expect_msg(64'hDEAD_BEEF_1234_FF74, 32'h0000_5A5A);
      pulse_irq(4);
      cfg_write(8'h5C, 4'b0011, 32'hFFFF_0001);
      expect_msg(64'hDEAD_BEEF_1234_FF74, 32'h0000_0001);
      pulse_irq(1);
      repeat (2) @(posedge clk);
      chk(exp_q.size() == 0, "R7 all messages seen", 96'(exp_q.size()), 96'h0);

      // R9 stall
      msg_ready = 1'b0;
      expect_msg(64'hDEAD_BEEF_1234_FF74, 32'h0000_0001);
      pulse_irq(1);
      #2;
      chk(msg_valid === 1'b1 && msg_data === 32'h1, "R9 held while stalled", {63'h0, msg_valid, msg_data}, {63'h0, 1'b1, 32'h1});
      cfg_write(8'h5C, 4'b0011, 32'h0000_7777);
      pulse_irq(1);
      #2;
      chk(msg_valid === 1'b1 && msg_data === 32'h1, "R9 stable after new edge", {63'h0, msg_valid, msg_data}, {63'h0, 1'b1, 32'h1});
      @(posedge clk); #1 msg_ready = 1'b1;
      repeat (4) @(posedge clk);
      #2;
      chk(msg_valid === 1'b0 && exp_q.size() == 0, "R9 single message released", {95'h0, msg_valid}, 96'h0);

      // R11 reset discards pending
      msg_ready = 1'b0;
      pulse_irq(1);
      #2;
      chk(msg_valid === 1'b1, "R11 pending before reset", {95'h0, msg_valid}, 96'h1);
      @(posedge clk); #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      #1;
      chk(msg_valid === 1'b0, "R11 pending discarded", {95'h0, msg_valid}, 96'h0);
      cfg_check(8'h50, 32'h0080_0005, "R11 enable cleared");
      msg_ready = 1'b1;
      repeat (4) @(posedge clk);
      chk(exp_q.size() == 0, "R11 no late message", 96'(exp_q.size()), 96'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule